// File: doc/BRIEF.md
# Cellular Automaton Random Word Generator

This block is a pseudo-random source for a hardware evolutionary search engine. Its state is an odd-length register of 2Q+1 cells that advances as a linear cellular automaton. Each cell takes the XOR of its two neighbours. Cells marked in a rule mask also XOR in their own value. Both ends see a constant zero beyond the edge. One state vector feeds two consumers at the same time: the parent-picking stage and the recombination/mutation stage.

From the one register the block extracts many Q-bit random words on every clock. The state is treated as a ring. A window of Q consecutive cells, read from any start cell and wrapping past the top cell back to cell 0, gives one word in the range 0 to 2^Q-1. Each of the 2Q+1 start cells yields its own word, so all rotations and all overlapping windows are available together. The raw cell vector is also exported, for use as recombination masks and mutation-position bits.

A seed can be loaded at any time. An all-zero seed is replaced by a fixed nonzero constant, so the automaton cannot stall. The state advances only while the enable input is high.

Top module: `ca_rng_gen`

## Requirements
- R1: While reset is asserted, and in the cycle it is released, the cell vector `rnd_bits` equals the parameter `SEED_DEFAULT` (default 9'h001 for Q=4).
- R2: A clock edge with `seed_load` high and a nonzero `seed` makes `rnd_bits` equal `seed` after that edge.
- R3: A clock edge with `seed_load` high and `seed` equal to zero makes `rnd_bits` equal `SEED_DEFAULT` after that edge.
- R4: A clock edge with `seed_load` low and `enable` high updates each cell i to left XOR right XOR (RULE_MASK[i] AND cell i). Here left is cell i-1 and right is cell i+1, and a neighbour outside 0..2Q is zero. The default RULE_MASK is all ones.
- R5: A clock edge with both `seed_load` and `enable` low leaves `rnd_bits` and `rnd_words` unchanged.
- R6: Word s (0 ≤ s ≤ 2Q) sits at `rnd_words[s*Q +: Q]`. Its bit j equals cell (s+j) mod (2Q+1), with bit 0 as the word's LSB. Words change in the same cycle as `rnd_bits`.
- R7: When `seed_load` and `enable` are both high, the load wins.
- R8: Out of reset, `rnd_bits` is never all zero. Elaboration rejects a rule mask whose transition matrix is singular.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load `seed` into the cell register |
| seed | input | 2Q+1 | Seed value; zero is replaced by `SEED_DEFAULT` |
| enable | input | 1 | Advance the automaton one step |
| rnd_bits | output | 2Q+1 | Registered cell vector |
| rnd_words | output | (2Q+1)*Q | Bank of Q-bit words, one per start cell |

## Verification
The bench checks the wrapped windows near the top cells, where an extractor that forgot the modulo would read past the vector or repeat low cells. It also checks the two boundary cells, where a design that wrapped the neighbours instead of using zero would drift from the expected sequence within a few steps. A zero-seed load that was not replaced would leave the register stuck at zero. Loading with enable also high tests the priority: a design that let the step win would show a stepped seed.

// File: rtl/ca_rng_pkg.sv
package ca_rng_pkg;

   localparam int unsigned CA_MAX_CELLS = 63;

   // Determinant over GF(2) of the tridiagonal step matrix: off-diagonals are
   // one, diagonal entry k is mask[k]. Nonzero means the step is invertible.
   function automatic logic ca_mask_nonsingular(input logic [CA_MAX_CELLS-1:0] mask,
                                                input int unsigned n);
      logic d_km2;
      logic d_km1;
      logic d_k;
      d_km2 = 1'b1;
      d_km1 = mask[0];
      for (int unsigned k = 1; k < CA_MAX_CELLS; k++) begin
         if (k < n) begin
            d_k   = (mask[k] & d_km1) ^ d_km2;
            d_km2 = d_km1;
            d_km1 = d_k;
         end
      end
      return d_km1;
   endfunction

endpackage

// File: rtl/ca_rng_seed_sel.sv
module ca_rng_seed_sel #(
   parameter int unsigned N = 9,
   parameter logic [N-1:0] SEED_DEFAULT = 1
) (
   input  logic [N-1:0] seed_in,
   output logic [N-1:0] seed_safe
);
   always_comb begin
      if (seed_in == '0) seed_safe = SEED_DEFAULT;
      else               seed_safe = seed_in;
   end
endmodule

// File: rtl/ca_rng_cells.sv
module ca_rng_cells #(
   parameter int unsigned N = 9,
   parameter logic [N-1:0] RULE_MASK = '1,
   parameter logic [N-1:0] SEED_DEFAULT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] load_val,
   input  logic         advance,
   output logic [N-1:0] cells
);
   logic [N-1:0] step_val;

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic nb_lo;
      logic nb_hi;
      if (i == 0) begin : g_lo_edge
         assign nb_lo = 1'b0;
      end else begin : g_lo_in
         assign nb_lo = cells[i-1];
      end
      if (i == N-1) begin : g_hi_edge
         assign nb_hi = 1'b0;
      end else begin : g_hi_in
         assign nb_hi = cells[i+1];
      end
      if (RULE_MASK[i]) begin : g_r150
         assign step_val[i] = nb_lo ^ nb_hi ^ cells[i];
      end else begin : g_r90
         assign step_val[i] = nb_lo ^ nb_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cells <= SEED_DEFAULT;
      else if (load)    cells <= load_val;
      else if (advance) cells <= step_val;
   end
endmodule

// File: rtl/ca_rng_windows.sv
module ca_rng_windows #(
   parameter int unsigned N = 9,
   parameter int unsigned Q = 4
) (
   input  logic [N-1:0]   cells,
   output logic [N*Q-1:0] words
);
   for (genvar s = 0; s < N; s++) begin : g_start
      for (genvar j = 0; j < Q; j++) begin : g_bit
         localparam int unsigned SRC = (s + j) % N;
         assign words[s*Q + j] = cells[SRC];
      end
   end
endmodule

// File: rtl/ca_rng_gen.sv
module ca_rng_gen #(
   parameter int unsigned Q = 4,
   localparam int unsigned N = 2*Q + 1,
   parameter logic [N-1:0] RULE_MASK = '1,
   parameter logic [N-1:0] SEED_DEFAULT = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           seed_load,
   input  logic [N-1:0]   seed,
   input  logic           enable,
   output logic [N-1:0]   rnd_bits,
   output logic [N*Q-1:0] rnd_words
);
   localparam logic [ca_rng_pkg::CA_MAX_CELLS-1:0] MASK_WIDE =
      {{(ca_rng_pkg::CA_MAX_CELLS-N){1'b0}}, RULE_MASK};

   if (Q < 2 || N > ca_rng_pkg::CA_MAX_CELLS) begin : g_bad_q
      $error("ca_rng_gen: Q out of range");
   end
   if (SEED_DEFAULT == '0) begin : g_bad_seed
      $error("ca_rng_gen: SEED_DEFAULT must be nonzero");
   end
   if (!ca_rng_pkg::ca_mask_nonsingular(MASK_WIDE, N)) begin : g_bad_mask
      $error("ca_rng_gen: RULE_MASK gives a singular step");
   end

   logic [N-1:0] seed_safe;

   ca_rng_seed_sel #(.N(N), .SEED_DEFAULT(SEED_DEFAULT)) u_seed (
      .seed_in  (seed),
      .seed_safe(seed_safe)
   );

   ca_rng_cells #(.N(N), .RULE_MASK(RULE_MASK), .SEED_DEFAULT(SEED_DEFAULT)) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (seed_load),
      .load_val(seed_safe),
      .advance (enable),
      .cells   (rnd_bits)
   );

   ca_rng_windows #(.N(N), .Q(Q)) u_win (
      .cells(rnd_bits),
      .words(rnd_words)
   );
endmodule

// File: rtl/ca_rng_gen_chk.sv
module ca_rng_gen_chk #(
   parameter int unsigned Q = 4,
   parameter int unsigned N = 9,
   parameter logic [N-1:0] SEED_DEFAULT = 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           seed_load,
   input logic [N-1:0]   seed,
   input logic           enable,
   input logic [N-1:0]   rnd_bits,
   input logic [N*Q-1:0] rnd_words
);
   assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> rnd_bits == SEED_DEFAULT);

   assert_seed_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed != '0) |=> rnd_bits == $past(seed));

   assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed == '0) |=> rnd_bits == SEED_DEFAULT);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_load && !enable) |=> ($stable(rnd_bits) && $stable(rnd_words)));

   assert_first_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_words[Q-1:0] == rnd_bits[Q-1:0]);

   assert_never_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_bits != '0);
endmodule

bind ca_rng_gen ca_rng_gen_chk #(.Q(Q), .N(N), .SEED_DEFAULT(SEED_DEFAULT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .seed_load(seed_load),
   .seed     (seed),
   .enable   (enable),
   .rnd_bits (rnd_bits),
   .rnd_words(rnd_words)
);

// File: tb/ca_rng_gen_test.sv
module ca_rng_gen_test;
   localparam int unsigned Q = 4;
   localparam int unsigned N = 2*Q + 1;
   localparam logic [N-1:0] SEED_DEF = 9'h001;
   localparam logic [N-1:0] MASK = 9'h1FF;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           seed_load = 1'b0;
   logic [N-1:0]   seed = '0;
   logic           enable = 1'b0;
   logic [N-1:0]   rnd_bits;
   logic [N*Q-1:0] rnd_words;

   int errors = 0;
   int checks = 0;
   logic [N-1:0] model_st = SEED_DEF;
   logic [N-1:0] exp_q[$];
   string        tag_q[$];

   always #4 clk = ~clk;

   ca_rng_gen #(.Q(Q)) uut (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
      .enable(enable), .rnd_bits(rnd_bits), .rnd_words(rnd_words)
   );

   function automatic logic [N-1:0] model_step(input logic [N-1:0] s);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         logic a, b;
         a = (i > 0)     ? s[i-1] : 1'b0;
         b = (i < N - 1) ? s[i+1] : 1'b0;
         r[i] = a ^ b ^ (MASK[i] & s[i]);
      end
      return r;
   endfunction

   function automatic logic [N*Q-1:0] model_words(input logic [N-1:0] s);
      logic [N*Q-1:0] w;
      for (int k = 0; k < N; k++)
         for (int j = 0; j < Q; j++)
            w[k*Q + j] = s[(k + j) % N];
      return w;
   endfunction

   task automatic check_state(input logic [N-1:0] exp, input string tag);
      checks++;
      if (rnd_bits !== exp) begin
         errors++;
         $display("FAIL %s bits: got %h expected %h", tag, rnd_bits, exp);
      end
      checks++;
      if (rnd_words !== model_words(exp)) begin
         errors++;
         $display("FAIL R6 words: got %h expected %h", rnd_words, model_words(exp));
      end
      checks++;
      if (rnd_bits == '0) begin
         errors++;
         $display("FAIL R8 zero state: got %h expected nonzero", rnd_bits);
      end
   endtask

   // driver: apply one cycle of stimulus and push the expected result
   task automatic drive(input logic ld, input logic [N-1:0] sd, input logic en,
                        input string tag);
      @(negedge clk);
      seed_load = ld;
      seed      = sd;
      enable    = en;
      if (ld)      model_st = (sd == '0) ? SEED_DEF : sd;
      else if (en) model_st = model_step(model_st);
      exp_q.push_back(model_st);
      tag_q.push_back(tag);
   endtask

   // monitor: compare after each active edge
   always @(posedge clk) begin
      #2;
      if (tag_q.size() > 0) begin
         logic [N-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check_state(e, t);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_state(SEED_DEF, "R1");
      rst_n = 1'b1;
      @(posedge clk); #2;
      check_state(SEED_DEF, "R1");
      drive(1'b1, 9'h1A5, 1'b0, "R2");
      for (int i = 0; i < 12; i++) drive(1'b0, 9'h000, 1'b1, "R4");
      for (int i = 0; i < 3; i++)  drive(1'b0, 9'h0F0, 1'b0, "R5");
      drive(1'b1, 9'h100, 1'b1, "R7");
      for (int i = 0; i < 6; i++)  drive(1'b0, 9'h000, 1'b1, "R4");
      drive(1'b1, 9'h000, 1'b0, "R3");
      drive(1'b1, 9'h000, 1'b1, "R3");
      for (int i = 0; i < 20; i++) drive(1'b0, 9'h000, 1'b1, "R4");
      drive(1'b0, 9'h1FF, 1'b0, "R5");
      drive(1'b1, 9'h1FF, 1'b0, "R2");
      for (int i = 0; i < 10; i++) drive(1'b0, 9'h000, 1'b1, "R4");
      drive(1'b0, 9'h000, 1'b0, "R5");
      @(negedge clk);
      seed_load = 1'b0;
      enable    = 1'b0;
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule